// File: doc/BRIEF.md
# Bit Manipulation and Skip Unit

This unit carries out single-bit work on one byte-wide register operand inside a small microcontroller-style core. Each cycle it may be handed a 16-bit instruction word together with the current value of the register that the word addresses. It decodes the word into one of five operations. Three of them modify the byte: clearing one bit, setting one bit, or inverting one bit. The other two test one bit and ask the fetch logic to skip the next instruction when the tested bit is zero, or when it is one.

The result appears one clock after the instruction is presented. A modifying operation raises a write enable for that single cycle, with the updated byte on the data output. A test operation never writes. Instead it reports a skip request, how many program words to skip, and how many cycles the instruction costs in total. The skip length comes from a fetch-stage flag that tells whether the following instruction occupies one word or two. The unit does not include the register file, operand addressing or fetch logic; it only passes the decoded address fields on to them. No status flag is read or changed.

Top module: `bitop_skip_unit`

## Requirements
- R1: Instruction bits [15:12] select the operation: 4'b1001 clears a bit, 4'b1000 sets a bit, 4'b0111 inverts a bit, 4'b1011 skips if the bit is 0, and 4'b1010 skips if the bit is 1.
- R2: For a recognised operation, `tgt_addr` equals instruction bits [7:0] and `tgt_bank` equals instruction bit [8], one cycle after the word is accepted. Bits [11:9] give the bit index, 0 to 7.
- R3: For clear, set and invert, `wr_en` is 1 in the cycle after acceptance. In that cycle `wr_data` equals the operand with only the indexed bit forced to 0, forced to 1, or inverted, and every other bit is unchanged.
- R4: Test operations never raise `wr_en`, and `wr_data` reads 0 for them.
- R5: A true test raises `skip_req`. `skip_words` is then 1 and `cyc_cost` is 2 when `next_two_word` is 0, and `skip_words` is 2 and `cyc_cost` is 3 when `next_two_word` is 1.
- R6: A false test leaves `skip_req` at 0 and `skip_words` at 0, and sets `cyc_cost` to 1.
- R7: Clear, set and invert set `cyc_cost` to 1, keep `skip_req` at 0, and ignore `next_two_word`.
- R8: An unrecognised opcode, or a cycle with `instr_vld` at 0, drives every output to 0 in the following cycle. This includes `cyc_cost`, `tgt_addr` and `tgt_bank`.
- R9: While `rst_n` is 0, every output is 0. Release of reset takes effect synchronously to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | An instruction word is presented this cycle |
| instr | input | 16 | Instruction word |
| opnd | input | 8 | Current value of the addressed register |
| next_two_word | input | 1 | The following instruction occupies two words |
| wr_en | output | 1 | Write the updated byte back |
| wr_data | output | 8 | Updated byte |
| skip_req | output | 1 | Skip the following instruction |
| skip_words | output | 2 | Number of program words to skip |
| cyc_cost | output | 2 | Cycles taken by this instruction |
| tgt_addr | output | 8 | Decoded register address field |
| tgt_bank | output | 1 | Decoded bank-select field |

## Verification
Each modifying operation is applied at every bit index to several operands: all ones, all zeros, and alternating patterns. A wrong mask, a shifted index or a wrong polarity then changes a visible bit. Both test operations are applied to bits that are set and to bits that are clear, with `next_two_word` at both values. This separates the polarity of the test from the 1-word and 2-word skip lengths. Opcodes next to the valid ones, idle cycles, and instructions issued back to back show that nothing is decoded by accident and that no write enable persists past its cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [2:0] {
    BOP_NONE = 3'd0,
    BOP_CLR  = 3'd1,
    BOP_SET  = 3'd2,
    BOP_INV  = 3'd3,
    BOP_SKZ  = 3'd4,
    BOP_SKO  = 3'd5
  } bop_e;

  localparam logic [3:0] OPC_CLR = 4'b1001;
  localparam logic [3:0] OPC_SET = 4'b1000;
  localparam logic [3:0] OPC_INV = 4'b0111;
  localparam logic [3:0] OPC_SKZ = 4'b1011;
  localparam logic [3:0] OPC_SKO = 4'b1010;

  function automatic logic bop_is_write(bop_e op);
    return (op == BOP_CLR) || (op == BOP_SET) || (op == BOP_INV);
  endfunction

  function automatic logic bop_is_test(bop_e op);
    return (op == BOP_SKZ) || (op == BOP_SKO);
  endfunction
endpackage

// File: rtl/bitop_rst_sync.sv
module bitop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int BANK_POS = ADDR_W,
  localparam int IDX_LO = ADDR_W + 1
) (
  input  logic               vld,
  input  logic [INSTR_W-1:0] word,
  output bop_e               op,
  output logic [IDX_W-1:0]   idx,
  output logic               bank,
  output logic [ADDR_W-1:0]  addr
);
  logic [3:0] opc;

  always_comb begin
    opc  = word[INSTR_W-1 -: 4];
    idx  = word[IDX_LO +: IDX_W];
    bank = word[BANK_POS];
    addr = word[ADDR_W-1:0];
    op   = BOP_NONE;
    if (vld) begin
      unique case (opc)
        OPC_CLR: op = BOP_CLR;
        OPC_SET: op = BOP_SET;
        OPC_INV: op = BOP_INV;
        OPC_SKZ: op = BOP_SKZ;
        OPC_SKO: op = BOP_SKO;
        default: op = BOP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  bop_e              op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] opnd,
  input  logic              next_two,
  output logic              wr,
  output logic [DATA_W-1:0] data,
  output logic              skip,
  output logic [1:0]        words,
  output logic [1:0]        cost
);
  logic [DATA_W-1:0] mask;
  logic              bit_val;
  logic              hit;

  always_comb begin
    mask    = DATA_W'(1) << idx;
    bit_val = |(opnd & mask);
    hit     = ((op == BOP_SKZ) && !bit_val) || ((op == BOP_SKO) && bit_val);
    wr      = bop_is_write(op);
    skip    = hit;
    data    = '0;
    words   = 2'd0;
    cost    = 2'd0;
    unique case (op)
      BOP_CLR: data = opnd & ~mask;
      BOP_SET: data = opnd | mask;
      BOP_INV: data = opnd ^ mask;
      default: data = '0;
    endcase
    if (wr) begin
      cost = 2'd1;
    end else if (bop_is_test(op)) begin
      if (hit) begin
        words = next_two ? 2'd2 : 2'd1;
        cost  = next_two ? 2'd3 : 2'd2;
      end else begin
        cost  = 2'd1;
      end
    end
  end
endmodule

// File: rtl/bitop_skip_unit.sv
module bitop_skip_unit
  import bitop_pkg::*;
#(
  parameter int INSTR_W   = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int RST_STAGES = 2,
  localparam int IDX_W    = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_vld,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opnd,
  input  logic               next_two_word,
  output logic               wr_en,
  output logic [DATA_W-1:0]  wr_data,
  output logic               skip_req,
  output logic [1:0]         skip_words,
  output logic [1:0]         cyc_cost,
  output logic [ADDR_W-1:0]  tgt_addr,
  output logic               tgt_bank
);
  logic              rst_n_s;
  bop_e              dec_op;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_bank;
  logic [ADDR_W-1:0] dec_addr;
  logic              ex_wr;
  logic [DATA_W-1:0] ex_data;
  logic              ex_skip;
  logic [1:0]        ex_words;
  logic [1:0]        ex_cost;
  logic              known;

  logic              wr_q, wr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              skip_q, skip_d;
  logic [1:0]        words_q, words_d;
  logic [1:0]        cost_q, cost_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              bank_q, bank_d;

  bitop_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_s)
  );

  bitop_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .vld(instr_vld), .word(instr), .op(dec_op), .idx(dec_idx),
    .bank(dec_bank), .addr(dec_addr)
  );

  bitop_exec #(.DATA_W(DATA_W)) u_exec (
    .op(dec_op), .idx(dec_idx), .opnd(opnd), .next_two(next_two_word),
    .wr(ex_wr), .data(ex_data), .skip(ex_skip), .words(ex_words), .cost(ex_cost)
  );

  always_comb begin
    known   = (dec_op != BOP_NONE);
    wr_d    = ex_wr;
    data_d  = ex_data;
    skip_d  = ex_skip;
    words_d = ex_words;
    cost_d  = ex_cost;
    addr_d  = known ? dec_addr : '0;
    bank_d  = known ? dec_bank : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_q    <= 1'b0;
      data_q  <= '0;
      skip_q  <= 1'b0;
      words_q <= 2'd0;
      cost_q  <= 2'd0;
      addr_q  <= '0;
      bank_q  <= 1'b0;
    end else begin
      wr_q    <= wr_d;
      data_q  <= data_d;
      skip_q  <= skip_d;
      words_q <= words_d;
      cost_q  <= cost_d;
      addr_q  <= addr_d;
      bank_q  <= bank_d;
    end
  end

  assign wr_en      = wr_q;
  assign wr_data    = data_q;
  assign skip_req   = skip_q;
  assign skip_words = words_q;
  assign cyc_cost   = cost_q;
  assign tgt_addr   = addr_q;
  assign tgt_bank   = bank_q;

  AST_WR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_en |-> $countones(wr_data ^ $past(opnd)) <= 1) else $error("one-bit change"); // R3
  AST_WR_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_en |-> (!skip_req && cyc_cost == 2'd1)) else $error("write with skip"); // R7
  AST_SKIP_LEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    skip_req |-> (skip_words == 2'd1 + {1'b0, $past(next_two_word)}
                  && cyc_cost == skip_words + 2'd1)) else $error("skip length"); // R5
  AST_TEST_NO_WR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (skip_req || skip_words != 2'd0) |-> (!wr_en && wr_data == '0)) else $error("test wrote"); // R4
  AST_NOSKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    !skip_req |-> skip_words == 2'd0) else $error("words without skip"); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(instr_vld) |-> (!wr_en && !skip_req && cyc_cost == 2'd0 && tgt_addr == '0))
    else $error("idle output"); // R8
  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cyc_cost != 2'd0) |-> tgt_addr == $past(instr[ADDR_W-1:0])) else $error("addr"); // R2
endmodule

// File: tb/bitop_skip_unit_tb.sv
module bitop_skip_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_vld;
  logic [15:0] instr;
  logic [7:0]  opnd;
  logic        next_two_word;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        skip_req;
  logic [1:0]  skip_words;
  logic [1:0]  cyc_cost;
  logic [7:0]  tgt_addr;
  logic        tgt_bank;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bitop_skip_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr), .opnd(opnd),
    .next_two_word(next_two_word), .wr_en(wr_en), .wr_data(wr_data),
    .skip_req(skip_req), .skip_words(skip_words), .cyc_cost(cyc_cost),
    .tgt_addr(tgt_addr), .tgt_bank(tgt_bank)
  );

  // packed view: wr(1) data(8) skip(1) words(2) cost(2) addr(8) bank(1) = 23 bits
  function automatic logic [22:0] obs();
    return {wr_en, wr_data, skip_req, skip_words, cyc_cost, tgt_addr, tgt_bank};
  endfunction

  function automatic logic [22:0] model(input logic vld, input logic [15:0] w,
                                        input logic [7:0] d, input logic two);
    logic [7:0] m;
    logic       b;
    m = 8'd1 << w[11:9];
    b = (d & m) != 8'd0;
    if (!vld) return '0;
    case (w[15:12])
      4'b1001: return {1'b1, d & ~m, 1'b0, 2'd0, 2'd1, w[7:0], w[8]};
      4'b1000: return {1'b1, d | m,  1'b0, 2'd0, 2'd1, w[7:0], w[8]};
      4'b0111: return {1'b1, d ^ m,  1'b0, 2'd0, 2'd1, w[7:0], w[8]};
      4'b1011: return !b ? {1'b0, 8'd0, 1'b1, two ? 2'd2 : 2'd1, two ? 2'd3 : 2'd2, w[7:0], w[8]}
                         : {1'b0, 8'd0, 1'b0, 2'd0, 2'd1, w[7:0], w[8]};
      4'b1010: return b ? {1'b0, 8'd0, 1'b1, two ? 2'd2 : 2'd1, two ? 2'd3 : 2'd2, w[7:0], w[8]}
                        : {1'b0, 8'd0, 1'b0, 2'd0, 2'd1, w[7:0], w[8]};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [22:0] exp);
    n_vec++;
    if (obs() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, obs(), exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sampled at following negedge
  task automatic apply(input string req, input logic [15:0] w, input logic [7:0] d,
                       input logic two);
    instr_vld = 1'b1; instr = w; opnd = d; next_two_word = two;
    @(negedge clk);
    check(req, model(1'b1, w, d, two));
  endtask

  task automatic go_idle(input string req);
    instr_vld = 1'b0; instr = 16'hFFFF; opnd = 8'hA5; next_two_word = 1'b1;
    @(negedge clk);
    check(req, '0);
  endtask

  function automatic logic [15:0] mk(input logic [3:0] opc, input int b,
                                     input logic bank, input logic [7:0] a);
    return {opc, 3'(b), bank, a};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; instr_vld = 1'b1; instr = mk(4'b1000, 3, 1'b1, 8'h44);
    opnd = 8'h00; next_two_word = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", '0);
    rst_n = 1'b1;
    instr_vld = 1'b0;
    repeat (4) @(negedge clk);
    check("R9", '0);
  endtask

  task automatic t_clear();
    for (int b = 0; b < 8; b++) begin
      apply("R3", mk(4'b1001, b, b[0], 8'(8'h10 + b)), 8'hFF, 1'b1);
      apply("R3", mk(4'b1001, b, 1'b0, 8'h3C), 8'h5A, 1'b0);
    end
    go_idle("R8");
  endtask

  task automatic t_set();
    for (int b = 0; b < 8; b++) begin
      apply("R1", mk(4'b1000, b, 1'b1, 8'hC3), 8'h00, 1'b0);
      apply("R3", mk(4'b1000, b, 1'b0, 8'h81), 8'hA5, 1'b1);
    end
    go_idle("R8");
  endtask

  task automatic t_invert();
    for (int b = 0; b < 8; b++) begin
      apply("R3", mk(4'b0111, b, 1'b0, 8'h7E), 8'h55, 1'b0);
      apply("R7", mk(4'b0111, b, 1'b1, 8'hE7), 8'hF0, 1'b1);
    end
    go_idle("R8");
  endtask

  task automatic t_skip_zero();
    for (int b = 0; b < 8; b++) begin
      apply("R5", mk(4'b1011, b, 1'b0, 8'h20), ~(8'd1 << b), 1'b0);
      apply("R5", mk(4'b1011, b, 1'b1, 8'h21), ~(8'd1 << b), 1'b1);
      apply("R6", mk(4'b1011, b, 1'b0, 8'h22), 8'd1 << b, 1'b1);
    end
    go_idle("R4");
  endtask

  task automatic t_skip_one();
    for (int b = 0; b < 8; b++) begin
      apply("R5", mk(4'b1010, b, 1'b1, 8'h90), 8'd1 << b, 1'b0);
      apply("R5", mk(4'b1010, b, 1'b0, 8'h91), 8'd1 << b, 1'b1);
      apply("R6", mk(4'b1010, b, 1'b1, 8'h92), ~(8'd1 << b), 1'b0);
    end
    go_idle("R4");
  endtask

  task automatic t_unknown();
    logic [3:0] bad [6] = '{4'b0000, 4'b0110, 4'b1100, 4'b1111, 4'b0001, 4'b1110};
    for (int i = 0; i < 6; i++) begin
      apply("R8", mk(bad[i], 5, 1'b1, 8'hEE), 8'hFF, 1'b1);
    end
    go_idle("R8");
  endtask

  task automatic t_fields();
    apply("R2", mk(4'b1001, 7, 1'b1, 8'hFF), 8'h80, 1'b0);
    apply("R2", mk(4'b1010, 0, 1'b0, 8'h00), 8'h01, 1'b0);
    apply("R2", mk(4'b0111, 4, 1'b1, 8'h5A), 8'h10, 1'b0);
    go_idle("R8");
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_clear();
    t_set();
    t_invert();
    t_skip_zero();
    t_skip_one();
    t_unknown();
    t_fields();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule